// File: doc/BRIEF.md
# Interleaved Tile Address Generator

This block turns an element coordinate into the byte offset of that element in an image held in an interleaved tiled layout. It can also turn a byte offset back into the coordinate. The image is cut into square tiles, and the tiles are stored one after another in raster order. Inside a tile, the elements follow a bit-interleaved curve. In that curve each y bit keeps its own position, and the x bit beside it is replaced by x XOR y.

Uncompressed formats use tiles of 16x16 pixels. Block-compressed formats use tiles of 4x4 compressed blocks, and the coordinates are then given in block units. Elements are only moved, never altered. The element size is a power of two from 1 to 16 bytes, so scaling by it is a left shift.

The forward path and the inverse path share the configuration inputs: tiles per row, element size and compressed mode. Each path has its own request strobe. Each result is registered one cycle after its request and then held until the next request on that path.

Top module: `utile_addr_gen`

## Requirements
- R1: After reset, `fwdValid` and `invValid` are 0, and `offOut`, `xOut` and `yOut` are 0.
- R2: `fwdValid` is 1 in exactly the cycle after a cycle with `fwdReq` high, and `offOut` carries that request's result then. `invValid` behaves the same way for `invReq`, `xOut` and `yOut`.
- R3: In uncompressed mode (`compMode`=0) the in-tile index is 8 bits wide. Its bit 2k+1 is y[k] and its bit 2k is x[k]^y[k], for k = 0..3. For example, (x=15, y=15) gives index 0xAA, (1,0) gives 1, (0,1) gives 3 and (1,1) gives 2.
- R4: In compressed mode (`compMode`=1) the tile edge is 4 and the in-tile index is 4 bits wide. Its bit 2k+1 is y[k] and its bit 2k is x[k]^y[k], for k = 0..1.
- R5: The tile number is (y>>e)*tilesPerRow + (x>>e), with e = 4 when uncompressed and e = 2 when compressed. The element number is tileNumber*2^(2e) + in-tile index.
- R6: The byte offset is the element number shifted left by `bppLog2`. Any `bppLog2` above 4 is treated as 4, so every offset is aligned to the element size.
- R7: The inverse path returns the original (x, y) for any offset the forward path makes with the same configuration, provided x < tilesPerRow*edge. Offset bits below the element size have no effect on the result.
- R8: On the inverse path, a `tilesPerRow` of 0 makes the tile row and column 0, so only the in-tile coordinates are returned.
- R9: While a path has no request, its outputs keep their last value, even when the coordinate, offset or configuration inputs change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| fwdReq | input | 1 | Start a coordinate-to-offset conversion |
| xIn | input | COORD_W | X coordinate (pixels, or blocks in compressed mode) |
| yIn | input | COORD_W | Y coordinate |
| invReq | input | 1 | Start an offset-to-coordinate conversion |
| offIn | input | OFF_W | Byte offset for the inverse path |
| tilesPerRow | input | TPR_W | Image width in tiles |
| bppLog2 | input | 3 | log2 of bytes per element (0..4; larger values mean 4) |
| compMode | input | 1 | 1 selects 4x4 block tiles, 0 selects 16x16 pixel tiles |
| fwdValid | output | 1 | Forward result valid |
| offOut | output | OFF_W | Byte offset result |
| invValid | output | 1 | Inverse result valid |
| xOut | output | COORD_W | Recovered x |
| yOut | output | COORD_W | Recovered y |

## Verification
The hardest case to reach from the ports is a wrong pairing of an x bit with its y bit that cancels out on the round trip. The forward and inverse paths could share the same mistake, and offsets would still decode back to the right coordinates. To catch that, the stimulus compares forward offsets against an independent bit-by-bit reference model. It also uses directed coordinates where x and y differ in single bits, such as (1,0), (0,1) and (15,15). Random offsets are also given junk low bits below the element size, to show that the inverse path drops them.

// File: rtl/utile_pkg.sv
package utile_pkg;
  // Strobes passed from control to datapath
  typedef struct packed {
    logic fwdLoad;
    logic invLoad;
  } ctlStrobe_t;

  localparam int FINE_EDGE_LOG   = 4;  // 16x16 pixel tile
  localparam int COARSE_EDGE_LOG = 2;  // 4x4 block tile
  localparam int MAX_BPP_LOG     = 4;  // 16 bytes per element
endpackage

// File: rtl/utile_swizzle.sv
module utile_swizzle #(
  parameter int PAIRS = 4
) (
  input  logic [PAIRS-1:0]   fwdX,
  input  logic [PAIRS-1:0]   fwdY,
  output logic [2*PAIRS-1:0] fwdIdx,
  input  logic [2*PAIRS-1:0] invIdx,
  output logic [PAIRS-1:0]   invX,
  output logic [PAIRS-1:0]   invY
);
  for (genvar k = 0; k < PAIRS; k++) begin : gPair
    // Odd index bit carries y, even index bit carries x XOR y
    assign fwdIdx[2*k+1] = fwdY[k];
    assign fwdIdx[2*k]   = fwdX[k] ^ fwdY[k];
    assign invY[k]       = invIdx[2*k+1];
    assign invX[k]       = invIdx[2*k] ^ invIdx[2*k+1];
  end
endmodule

// File: rtl/utile_ctrl.sv
module utile_ctrl
  import utile_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       fwdReq,
  input  logic       invReq,
  output ctlStrobe_t strobe,
  output logic       fwdValid,
  output logic       invValid
);
  always_comb begin
    strobe.fwdLoad = fwdReq;
    strobe.invLoad = invReq;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      fwdValid <= 1'b0;
      invValid <= 1'b0;
    end else begin
      fwdValid <= fwdReq;
      invValid <= invReq;
    end
  end
endmodule

// File: rtl/utile_dp.sv
module utile_dp
  import utile_pkg::*;
#(
  parameter int COORD_W = 16,
  parameter int TPR_W   = 12,
  parameter int OFF_W   = COORD_W + TPR_W + 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  ctlStrobe_t         strobe,
  input  logic [COORD_W-1:0] xIn,
  input  logic [COORD_W-1:0] yIn,
  input  logic [OFF_W-1:0]   offIn,
  input  logic [TPR_W-1:0]   tilesPerRow,
  input  logic [2:0]         bppLog2,
  input  logic               compMode,
  output logic [OFF_W-1:0]   offOut,
  output logic [COORD_W-1:0] xOut,
  output logic [COORD_W-1:0] yOut
);
  localparam int FINE_IDX_W   = 2 * FINE_EDGE_LOG;
  localparam int COARSE_IDX_W = 2 * COARSE_EDGE_LOG;

  logic [2:0] bppEff;
  assign bppEff = (bppLog2 > 3'(MAX_BPP_LOG)) ? 3'(MAX_BPP_LOG) : bppLog2;

  // Swizzle units for both tile sizes
  logic [FINE_IDX_W-1:0]      fineIdx;
  logic [COARSE_IDX_W-1:0]    coarseIdx;
  logic [OFF_W-1:0]           elemBack;
  logic [FINE_EDGE_LOG-1:0]   fineXb, fineYb;
  logic [COARSE_EDGE_LOG-1:0] coarseXb, coarseYb;

  utile_swizzle #(.PAIRS(FINE_EDGE_LOG)) uFine (
    .fwdX(xIn[FINE_EDGE_LOG-1:0]), .fwdY(yIn[FINE_EDGE_LOG-1:0]),
    .fwdIdx(fineIdx),
    .invIdx(elemBack[FINE_IDX_W-1:0]),
    .invX(fineXb), .invY(fineYb)
  );

  utile_swizzle #(.PAIRS(COARSE_EDGE_LOG)) uCoarse (
    .fwdX(xIn[COARSE_EDGE_LOG-1:0]), .fwdY(yIn[COARSE_EDGE_LOG-1:0]),
    .fwdIdx(coarseIdx),
    .invIdx(elemBack[COARSE_IDX_W-1:0]),
    .invX(coarseXb), .invY(coarseYb)
  );

  // Forward: coordinate to byte offset
  logic [COORD_W-1:0] tileX, tileY;
  logic [OFF_W-1:0]   tileNum, elemNum, offNext;

  always_comb begin
    if (compMode) begin
      tileX   = xIn >> COARSE_EDGE_LOG;
      tileY   = yIn >> COARSE_EDGE_LOG;
    end else begin
      tileX   = xIn >> FINE_EDGE_LOG;
      tileY   = yIn >> FINE_EDGE_LOG;
    end
    tileNum = OFF_W'(tileY) * OFF_W'(tilesPerRow) + OFF_W'(tileX);
    if (compMode)
      elemNum = (tileNum << COARSE_IDX_W) | OFF_W'(coarseIdx);
    else
      elemNum = (tileNum << FINE_IDX_W) | OFF_W'(fineIdx);
    offNext = elemNum << bppEff;
  end

  // Inverse: byte offset to coordinate
  logic [OFF_W-1:0]   tileBack, tprWide, rowBack, colBack;
  logic [COORD_W-1:0] xNext, yNext;

  always_comb begin
    elemBack = offIn >> bppEff;
    tprWide  = OFF_W'(tilesPerRow);
    if (compMode) tileBack = elemBack >> COARSE_IDX_W;
    else          tileBack = elemBack >> FINE_IDX_W;
    if (tilesPerRow == '0) begin
      rowBack = '0;
      colBack = '0;
    end else begin
      rowBack = tileBack / tprWide;
      colBack = tileBack % tprWide;
    end
    if (compMode) begin
      xNext = COORD_W'((colBack << COARSE_EDGE_LOG) | OFF_W'(coarseXb));
      yNext = COORD_W'((rowBack << COARSE_EDGE_LOG) | OFF_W'(coarseYb));
    end else begin
      xNext = COORD_W'((colBack << FINE_EDGE_LOG) | OFF_W'(fineXb));
      yNext = COORD_W'((rowBack << FINE_EDGE_LOG) | OFF_W'(fineYb));
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      offOut <= '0;
      xOut   <= '0;
      yOut   <= '0;
    end else begin
      if (strobe.fwdLoad) offOut <= offNext;
      if (strobe.invLoad) begin
        xOut <= xNext;
        yOut <= yNext;
      end
    end
  end
endmodule

// File: rtl/utile_addr_gen.sv
module utile_addr_gen
  import utile_pkg::*;
#(
  parameter int COORD_W = 16,
  parameter int TPR_W   = 12,
  parameter int OFF_W   = COORD_W + TPR_W + 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               fwdReq,
  input  logic [COORD_W-1:0] xIn,
  input  logic [COORD_W-1:0] yIn,
  input  logic               invReq,
  input  logic [OFF_W-1:0]   offIn,
  input  logic [TPR_W-1:0]   tilesPerRow,
  input  logic [2:0]         bppLog2,
  input  logic               compMode,
  output logic               fwdValid,
  output logic [OFF_W-1:0]   offOut,
  output logic               invValid,
  output logic [COORD_W-1:0] xOut,
  output logic [COORD_W-1:0] yOut
);
  ctlStrobe_t strobe;

  utile_ctrl uCtrl (
    .clk(clk), .rstN(rstN), .fwdReq(fwdReq), .invReq(invReq),
    .strobe(strobe), .fwdValid(fwdValid), .invValid(invValid)
  );

  utile_dp #(.COORD_W(COORD_W), .TPR_W(TPR_W), .OFF_W(OFF_W)) uDp (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .xIn(xIn), .yIn(yIn), .offIn(offIn), .tilesPerRow(tilesPerRow),
    .bppLog2(bppLog2), .compMode(compMode),
    .offOut(offOut), .xOut(xOut), .yOut(yOut)
  );
endmodule

// File: rtl/utile_addr_gen_chk.sv
module utile_addr_gen_chk #(
  parameter int COORD_W = 16,
  parameter int OFF_W   = 36
) (
  input logic               clk,
  input logic               rstN,
  input logic               fwdReq,
  input logic               invReq,
  input logic [2:0]         bppLog2,
  input logic               fwdValid,
  input logic               invValid,
  input logic [OFF_W-1:0]   offOut,
  input logic [COORD_W-1:0] xOut,
  input logic [COORD_W-1:0] yOut
);
  function automatic logic [OFF_W-1:0] lowMask(logic [2:0] b);
    logic [2:0] e;
    e = (b > 3'd4) ? 3'd4 : b;
    return (OFF_W'(1) << e) - OFF_W'(1);
  endfunction

  a_r2_fwd_valid: assert property (@(posedge clk) disable iff (!rstN)
    fwdReq |=> fwdValid);
  a_r2_fwd_idle: assert property (@(posedge clk) disable iff (!rstN)
    !fwdReq |=> !fwdValid);
  a_r2_inv_valid: assert property (@(posedge clk) disable iff (!rstN)
    invReq |=> invValid);
  a_r9_fwd_hold: assert property (@(posedge clk) disable iff (!rstN)
    !fwdReq |=> $stable(offOut));
  a_r9_inv_hold: assert property (@(posedge clk) disable iff (!rstN)
    !invReq |=> ($stable(xOut) && $stable(yOut)));
  a_r6_aligned: assert property (@(posedge clk) disable iff (!rstN)
    fwdReq |=> ((offOut & lowMask($past(bppLog2))) == '0));
endmodule

bind utile_addr_gen utile_addr_gen_chk #(.COORD_W(COORD_W), .OFF_W(OFF_W)) uChk (
  .clk(clk), .rstN(rstN), .fwdReq(fwdReq), .invReq(invReq), .bppLog2(bppLog2),
  .fwdValid(fwdValid), .invValid(invValid), .offOut(offOut),
  .xOut(xOut), .yOut(yOut)
);

// File: tb/utile_addr_gen_test.sv
`timescale 1ns/1ps
module utile_addr_gen_test;
  localparam int COORD_W = 16;
  localparam int TPR_W   = 12;
  localparam int OFF_W   = COORD_W + TPR_W + 8;

  logic               clk = 1'b0;
  logic               rstN = 1'b0;
  logic               fwdReq = 1'b0, invReq = 1'b0, compMode = 1'b0;
  logic [COORD_W-1:0] xIn = '0, yIn = '0;
  logic [OFF_W-1:0]   offIn = '0;
  logic [TPR_W-1:0]   tilesPerRow = '0;
  logic [2:0]         bppLog2 = '0;
  logic               fwdValid, invValid;
  logic [OFF_W-1:0]   offOut;
  logic [COORD_W-1:0] xOut, yOut;

  int total = 0;
  int bad = 0;

  always #2.5 clk = ~clk;

  utile_addr_gen #(.COORD_W(COORD_W), .TPR_W(TPR_W)) uut (
    .clk(clk), .rstN(rstN), .fwdReq(fwdReq), .xIn(xIn), .yIn(yIn),
    .invReq(invReq), .offIn(offIn), .tilesPerRow(tilesPerRow),
    .bppLog2(bppLog2), .compMode(compMode), .fwdValid(fwdValid),
    .offOut(offOut), .invValid(invValid), .xOut(xOut), .yOut(yOut)
  );

  task automatic checkVal(string req, longint unsigned act, longint unsigned exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Reference model written from the requirement text, bit by bit
  function automatic longint unsigned refOffset(int unsigned x, int unsigned y,
      int unsigned tpr, int unsigned bpp, bit comp);
    int unsigned el = comp ? 2 : 4;
    longint unsigned idx = 0;
    longint unsigned tile;
    int unsigned b = (bpp > 4) ? 4 : bpp;
    for (int k = 0; k < el; k++) begin
      idx += longint'((y >> k) & 1) * (64'd1 << (2*k+1));
      idx += longint'(((x >> k) ^ (y >> k)) & 1) * (64'd1 << (2*k));
    end
    tile = longint'(y >> el) * tpr + longint'(x >> el);
    return (tile * (64'd1 << (2*el)) + idx) * (64'd1 << b);
  endfunction

  task automatic doFwd(int unsigned x, int unsigned y, int unsigned tpr,
      int unsigned bpp, bit comp, output longint unsigned got);
    @(negedge clk);
    xIn = COORD_W'(x); yIn = COORD_W'(y); tilesPerRow = TPR_W'(tpr);
    bppLog2 = 3'(bpp); compMode = comp; fwdReq = 1'b1;
    @(negedge clk);
    fwdReq = 1'b0;
    checkVal("R2 fwdValid", longint'(fwdValid), 1);
    got = longint'(offOut);
  endtask

  task automatic doInv(longint unsigned off, int unsigned tpr, int unsigned bpp,
      bit comp, output int unsigned gx, output int unsigned gy);
    @(negedge clk);
    offIn = OFF_W'(off); tilesPerRow = TPR_W'(tpr);
    bppLog2 = 3'(bpp); compMode = comp; invReq = 1'b1;
    @(negedge clk);
    invReq = 1'b0;
    checkVal("R2 invValid", longint'(invValid), 1);
    gx = int'(xOut); gy = int'(yOut);
  endtask

  initial begin
    #1000000;
    total++; bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    longint unsigned got, held;
    int unsigned gx, gy;
    void'($urandom(32'd12345));
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    checkVal("R1 fwdValid", longint'(fwdValid), 0);
    checkVal("R1 invValid", longint'(invValid), 0);
    checkVal("R1 offOut", longint'(offOut), 0);
    checkVal("R1 xOut", longint'(xOut), 0);
    checkVal("R1 yOut", longint'(yOut), 0);

    // R3 directed in-tile order
    doFwd(1, 0, 1, 0, 0, got);  checkVal("R3 (1,0)", got, 1);
    doFwd(0, 1, 1, 0, 0, got);  checkVal("R3 (0,1)", got, 3);
    doFwd(1, 1, 1, 0, 0, got);  checkVal("R3 (1,1)", got, 2);
    doFwd(15, 15, 1, 0, 0, got); checkVal("R3 (15,15)", got, 170);
    doFwd(8, 0, 1, 0, 0, got);  checkVal("R3 (8,0)", got, 64);
    // R5 tile raster
    doFwd(16, 0, 2, 0, 0, got); checkVal("R5 tile1", got, 256);
    doFwd(0, 16, 3, 0, 0, got); checkVal("R5 row1", got, 768);
    // R4 compressed tiles
    doFwd(3, 3, 3, 0, 1, got);  checkVal("R4 (3,3)", got, 10);
    doFwd(4, 0, 3, 4, 1, got);  checkVal("R4 R6 tile1 16B", got, 256);
    doFwd(0, 4, 3, 0, 1, got);  checkVal("R4 row1", got, 48);
    // R6 clamp above 4
    doFwd(5, 9, 4, 7, 0, got);  checkVal("R6 clamp", got, refOffset(5, 9, 4, 4, 0));
    doFwd(5, 9, 4, 2, 0, got);  checkVal("R6 shift", got, refOffset(5, 9, 4, 0, 0) * 4);

    // R9 hold: change inputs without request
    held = got;
    @(negedge clk);
    xIn = 16'h1234; yIn = 16'h0777; bppLog2 = 3'd1; compMode = 1'b1;
    @(negedge clk);
    checkVal("R9 offOut hold", longint'(offOut), held);
    checkVal("R2 fwdValid idle", longint'(fwdValid), 0);

    // R8 zero tiles per row on inverse: tile 1000, in-tile (5,3)
    doInv((longint'(1000) << 8) + refOffset(5, 3, 1, 0, 0), 0, 0, 0, gx, gy);
    checkVal("R8 x", gx, 5);
    checkVal("R8 y", gy, 3);
    @(negedge clk);
    offIn = '1;
    @(negedge clk);
    checkVal("R9 xOut hold", longint'(xOut), 5);
    checkVal("R9 yOut hold", longint'(yOut), 3);

    // Random forward and round trip, R5 R6 R7
    for (int i = 0; i < 1500; i++) begin
      bit comp = 1'($urandom % 2);
      int unsigned edgeSz = comp ? 4 : 16;
      int unsigned tpr = 1 + $urandom % 50;
      int unsigned x = $urandom % (tpr * edgeSz);
      int unsigned y = $urandom % 2000;
      int unsigned bpp = $urandom % 8;
      int unsigned b = (bpp > 4) ? 4 : bpp;
      longint unsigned junk;
      doFwd(x, y, tpr, bpp, comp, got);
      checkVal("R5 random offset", got, refOffset(x, y, tpr, bpp, comp));
      junk = longint'($urandom % (32'd1 << b));
      doInv(got + junk, tpr, bpp, comp, gx, gy);
      checkVal("R7 round trip x", gx, x);
      checkVal("R7 round trip y", gy, y);
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule